// File: doc/BRIEF.md
# Dual-channel byte-loaded DAC code register

This block is the host-side register file of a dual 12-bit digital-to-analog converter. The host drives a byte-wide data bus and a 2-bit address. It also drives active-low select, write, update and clear strobes, and the block samples all of these on a system clock. Each channel holds its 12-bit word in two staging registers: an 8-bit low part and a 4-bit high part. The address picks which staging register a write fills.

An update transfer copies the staged words of both channels into their output code registers at the same edge, so the two converters change together. When select and update are asserted together, a write passes straight through to the outputs. Clear zeroes every register and overrides every other input. A one-cycle strobe marks each cycle in which either output code takes a new value.

Top module: `dual_dac_bus_if`

## Requirements
- R1: A sampled low on clr_ni sets both staging registers of both channels and both output codes to zero, whatever the other inputs are.
- R2: With cs_ni and wr_ni low, address 0 stores data_i[7:0] into channel A's low staging register. Address 1 stores data_i[3:0] into channel A's high staging register, and data_i[3] becomes code bit 11.
- R3: Address 2 and address 3 store into channel B's low and high staging registers, with the same bit mapping as in R2.
- R4: A write with cs_ni low and upd_ni high changes only staging registers. Both output codes keep their values.
- R5: With wr_ni and upd_ni low and cs_ni high, both output codes load their full staged words at the same clock edge. The new values are visible after that edge.
- R6: With cs_ni, wr_ni and upd_ni all low, the written staging register and both output codes update at the same edge, so the outputs show the written data one cycle later.
- R7: When wr_ni is high, or when cs_ni and upd_ni are both high, no register changes.
- R8: Each output code is the high staging nibble in bits 11..8 followed by the low staging byte in bits 7..0.
- R9: chg_o is high for exactly the cycles in which code_a_o or code_b_o differs from its value in the previous cycle.
- R10: Asserting rst_ni low zeroes the codes and chg_o at once, without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; all bus pins sampled on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Active-low select |
| wr_ni | input | 1 | Active-low write strobe |
| upd_ni | input | 1 | Active-low update (transfer) strobe |
| clr_ni | input | 1 | Active-low clear of all registers |
| addr_i | input | 2 | Staging register address: bit 1 selects the channel, bit 0 selects the high part |
| data_i | input | 8 | Write data |
| code_a_o | output | 12 | Channel A output code |
| code_b_o | output | 12 | Channel B output code |
| chg_o | output | 1 | One-cycle strobe when either code changes |

## Verification
Two functions can fall in the same cycle: a write into a staging register and the transfer into the output codes. The transparent mode makes both happen in one sample. The bench provokes this by holding select, write and update low together and writing single parts of a word. It judges the result by checking that the output shows the new part merged with the other part that was already staged. It also checks that a write with update high leaves the outputs untouched, and that clear applied during a transfer wins over it.

// File: rtl/dac_if_pkg.sv
package dac_if_pkg;
  typedef struct packed {
    logic       clr;
    logic       load;
    logic       xfer;
    logic [1:0] sel;
  } bus_op_t;
endpackage

// File: rtl/dac_bus_decode.sv
module dac_bus_decode
  import dac_if_pkg::*;
(
  input  logic       cs_ni,
  input  logic       wr_ni,
  input  logic       upd_ni,
  input  logic       clr_ni,
  input  logic [1:0] addr_i,
  output bus_op_t    op_o
);
  always_comb begin
    op_o.clr  = ~clr_ni;
    op_o.load = clr_ni & ~wr_ni & ~cs_ni;
    op_o.xfer = clr_ni & ~wr_ni & ~upd_ni;
    op_o.sel  = addr_i;
  end
endmodule

// File: rtl/dac_input_bank.sv
module dac_input_bank #(
  parameter int LO_W  = 8,
  parameter int HI_W  = 4,
  parameter int CH_ID = 0,
  localparam int CODE_W = LO_W + HI_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              load_i,
  input  logic [1:0]        sel_i,
  input  logic [LO_W-1:0]   data_i,
  output logic [CODE_W-1:0] code_nxt_o
);
  localparam logic CH_BIT = CH_ID[0];

  logic [LO_W-1:0] lo_q, lo_d;
  logic [HI_W-1:0] hi_q, hi_d;
  logic            hit_lo, hit_hi;

  assign hit_lo = load_i && (sel_i == {CH_BIT, 1'b0});
  assign hit_hi = load_i && (sel_i == {CH_BIT, 1'b1});

  always_comb begin
    lo_d = lo_q;
    hi_d = hi_q;
    if (clr_i) begin
      lo_d = '0;
      hi_d = '0;
    end else begin
      if (hit_lo) lo_d = data_i;
      if (hit_hi) hi_d = data_i[HI_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end

  // staged word as it will be after this edge; feeds transparent transfer
  assign code_nxt_o = {hi_d, lo_d};
endmodule

// File: rtl/dac_out_reg.sv
module dac_out_reg #(
  parameter int CODE_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              xfer_i,
  input  logic [CODE_W-1:0] code_nxt_i,
  output logic [CODE_W-1:0] code_o,
  output logic              change_o
);
  logic [CODE_W-1:0] code_d;

  always_comb begin
    code_d = code_o;
    if (clr_i)       code_d = '0;
    else if (xfer_i) code_d = code_nxt_i;
  end

  assign change_o = (code_d != code_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) code_o <= '0;
    else         code_o <= code_d;
  end
endmodule

// File: rtl/dual_dac_bus_if.sv
module dual_dac_bus_if
  import dac_if_pkg::*;
#(
  parameter int LO_W = 8,
  parameter int HI_W = 4,
  localparam int CODE_W = LO_W + HI_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              wr_ni,
  input  logic              upd_ni,
  input  logic              clr_ni,
  input  logic [1:0]        addr_i,
  input  logic [LO_W-1:0]   data_i,
  output logic [CODE_W-1:0] code_a_o,
  output logic [CODE_W-1:0] code_b_o,
  output logic              chg_o
);
  localparam int NUM_CH = 2;

  bus_op_t           op;
  logic [CODE_W-1:0] nxt_w  [NUM_CH];
  logic [CODE_W-1:0] code_w [NUM_CH];
  logic [NUM_CH-1:0] chg_w;

  dac_bus_decode u_dec (
    .cs_ni  (cs_ni),
    .wr_ni  (wr_ni),
    .upd_ni (upd_ni),
    .clr_ni (clr_ni),
    .addr_i (addr_i),
    .op_o   (op)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    dac_input_bank #(.LO_W(LO_W), .HI_W(HI_W), .CH_ID(c)) u_bank (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .clr_i      (op.clr),
      .load_i     (op.load),
      .sel_i      (op.sel),
      .data_i     (data_i),
      .code_nxt_o (nxt_w[c])
    );
    dac_out_reg #(.CODE_W(CODE_W)) u_out (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .clr_i      (op.clr),
      .xfer_i     (op.xfer),
      .code_nxt_i (nxt_w[c]),
      .code_o     (code_w[c]),
      .change_o   (chg_w[c])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chg_o <= 1'b0;
    else         chg_o <= |chg_w;
  end

  assign code_a_o = code_w[0];
  assign code_b_o = code_w[1];
endmodule

// File: rtl/dual_dac_bus_if_chk.sv
module dual_dac_bus_if_chk #(
  parameter int LO_W = 8,
  parameter int HI_W = 4,
  localparam int CODE_W = LO_W + HI_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_ni,
  input logic              wr_ni,
  input logic              upd_ni,
  input logic              clr_ni,
  input logic [1:0]        addr_i,
  input logic [LO_W-1:0]   data_i,
  input logic [CODE_W-1:0] code_a_o,
  input logic [CODE_W-1:0] code_b_o,
  input logic              chg_o
);
  a_r1_clear_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_ni |=> (code_a_o == '0) && (code_b_o == '0));

  a_r4_write_only_staging: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_ni && !cs_ni && !wr_ni && upd_ni) |=> $stable(code_a_o) && $stable(code_b_o));

  a_r6_transparent_low_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_ni && !cs_ni && !wr_ni && !upd_ni && addr_i == 2'd0)
      |=> code_a_o[LO_W-1:0] == $past(data_i));

  a_r7_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_ni && (wr_ni || (cs_ni && upd_ni))) |=> $stable(code_a_o) && $stable(code_b_o));

  a_r9_change_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_o == ((code_a_o != $past(code_a_o)) || (code_b_o != $past(code_b_o))));
endmodule

bind dual_dac_bus_if dual_dac_bus_if_chk #(.LO_W(LO_W), .HI_W(HI_W)) u_chk (.*);

// File: tb/dual_dac_bus_if_tb.sv
`timescale 1ns/1ps
module dual_dac_bus_if_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cs_ni = 1'b1, wr_ni = 1'b1, upd_ni = 1'b1, clr_ni = 1'b1;
  logic [1:0]  addr_i = '0;
  logic [7:0]  data_i = '0;
  logic [11:0] code_a_o, code_b_o;
  logic        chg_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk_i = ~clk_i;

  dual_dac_bus_if u_dut (.*);

  // {clr, cs, wr, upd, addr[1:0], data[7:0], exp_a[11:0], exp_b[11:0], exp_chg}
  localparam int NV = 15;
  localparam logic [38:0] VEC [NV] = '{
    {1'b1,1'b0,1'b0,1'b1,2'd0,8'h5A,12'h000,12'h000,1'b0},
    {1'b1,1'b0,1'b0,1'b1,2'd1,8'hF3,12'h000,12'h000,1'b0},
    {1'b1,1'b0,1'b0,1'b1,2'd2,8'hC4,12'h000,12'h000,1'b0},
    {1'b1,1'b0,1'b0,1'b1,2'd3,8'h19,12'h000,12'h000,1'b0},
    {1'b1,1'b1,1'b1,1'b1,2'd0,8'h00,12'h000,12'h000,1'b0},
    {1'b1,1'b1,1'b0,1'b0,2'd0,8'h00,12'h35A,12'h9C4,1'b1},
    {1'b1,1'b1,1'b0,1'b0,2'd0,8'h00,12'h35A,12'h9C4,1'b0},
    {1'b1,1'b1,1'b0,1'b1,2'd0,8'hEE,12'h35A,12'h9C4,1'b0},
    {1'b1,1'b0,1'b1,1'b0,2'd0,8'hEE,12'h35A,12'h9C4,1'b0},
    {1'b1,1'b0,1'b0,1'b0,2'd0,8'h01,12'h301,12'h9C4,1'b1},
    {1'b1,1'b0,1'b0,1'b0,2'd3,8'hF7,12'h301,12'h7C4,1'b1},
    {1'b1,1'b0,1'b0,1'b1,2'd2,8'h00,12'h301,12'h7C4,1'b0},
    {1'b0,1'b1,1'b0,1'b0,2'd0,8'h00,12'h000,12'h000,1'b1},
    {1'b1,1'b1,1'b0,1'b0,2'd0,8'h00,12'h000,12'h000,1'b0},
    {1'b0,1'b0,1'b0,1'b0,2'd0,8'hFF,12'h000,12'h000,1'b0}
  };
  string vtag [NV] = '{"R2","R2 R8","R3","R3 R8","R7","R5 R9","R5 R9","R7",
                       "R7","R6","R6","R4","R1","R1","R1"};

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual hung, expected finished");
    summary();
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk_i);
    #1;
    chk("R10", "reset code_a", code_a_o, 0);
    chk("R10", "reset code_b", code_b_o, 0);
    chk("R10", "reset chg", chg_o, 0);
    @(negedge clk_i) rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      {clr_ni, cs_ni, wr_ni, upd_ni, addr_i, data_i} = VEC[i][38:25];
      @(posedge clk_i);
      #1;
      chk(vtag[i], "code_a", code_a_o, VEC[i][24:13]);
      chk(vtag[i], "code_b", code_b_o, VEC[i][12:1]);
      chk(vtag[i], "chg", chg_o, VEC[i][0]);
    end

    // transparent high-part write merges with cleared low part
    @(negedge clk_i);
    {clr_ni, cs_ni, wr_ni, upd_ni, addr_i, data_i} = {1'b1,1'b0,1'b0,1'b0,2'd1,8'h0A};
    @(posedge clk_i);
    #1;
    chk("R6", "merge code_a", code_a_o, 12'hA00);
    chk("R9", "merge chg", chg_o, 1);
    @(negedge clk_i);
    {cs_ni, wr_ni, upd_ni} = 3'b111;
    @(posedge clk_i);
    #1;
    chk("R9", "strobe one cycle", chg_o, 0);

    // asynchronous reset mid-cycle
    #0.5 rst_ni = 1'b0;
    #0.5;
    chk("R10", "async code_a", code_a_o, 0);
    chk("R10", "async chg", chg_o, 0);
    @(negedge clk_i) rst_ni = 1'b1;
    @(posedge clk_i);
    #1;
    chk("R10", "after reset code_a", code_a_o, 0);

    summary();
    $finish;
  end
endmodule